// File: doc/BRIEF.md
# DMA Channel Fault and Interrupt Request Logic

This block sits beside one memory-to-memory DMA channel and decides two things: whether the channel may run, and whether it should raise its interrupt line. When software turns the channel on, the block checks the programmed source and destination addresses against the selected transfer width. In scatter/gather mode it also checks the descriptor address. A misaligned address faults the channel at once. While the channel runs, the block watches bus timeouts and slave errors. It holds back a slave-error report until any read/write pair already in flight has finished.

Terminal count, end of transfer and error are latched in sticky status bits. Software clears them by writing ones. A level interrupt request is formed from these bits, the channel interrupt enable and the terminal-count enable. In scatter/gather mode, three further qualifiers from the current descriptor gate the request. The data movers, descriptor fetch, bus master and interrupt controller sit outside this block.

Top module: `dma_chan_errirq`

## Requirements
- R1: `xfer_width` sets the required alignment of `src_addr` and `dst_addr`. Code 0 needs byte alignment, code 1 needs 2-byte, code 2 needs 4-byte and code 3 needs 8-byte alignment. Any address bit below that boundary set to 1 is a misalignment.
- R2: When `sg_mode` is 1, `desc_addr` must have bits [1:0] equal to 0, whatever `xfer_width` is. When `sg_mode` is 0, `desc_addr` is not checked.
- R3: Suppose `ch_en` is first sampled high at a clock edge. If every checked address is aligned, `busy` is 1 after that edge and `st_err` is unchanged. If any checked address is misaligned, `st_err` is 1 and `busy` is 0 after that edge.
- R4: A `bus_tmo` pulse sets `st_err` and clears `busy` at the next clock edge.
- R5: Suppose `slv_err` arrives while `pair_active` is 1 and `pair_done` is 0. Then `st_err` stays 0 until an edge where `pair_done` is 1 (or `pair_active` is 0). At that edge `st_err` sets and `busy` clears.
- R6: A `slv_err` with `pair_active` at 0, or together with `pair_done`, sets `st_err` at the next clock edge.
- R7: While `irq_en` is 0, `irq` is 0 whatever the status is.
- R8: When `sg_mode` is 0 and `irq_en` is 1, `irq` is 1 exactly while any of these holds: `tc_en` and `st_tc` are both 1, `st_eot` is 1, or `st_err` is 1.
- R9: When `sg_mode` is 1, each of the three causes in R8 is further ANDed with its own qualifier: `q_tc` for terminal count, `q_eot` for end of transfer and `q_err` for error.
- R10: `tc_evt` sets `st_tc` and `eot_evt` sets `st_eot`. All status bits are sticky. A cycle with `clr_wr` at 1 clears the bits set in `clr_mask`: bit 0 clears `st_tc`, bit 1 clears `st_eot` and bit 2 clears `st_err`. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R11: After an alignment, timeout or slave error fault, `busy` stays 0 even if `st_err` is cleared. It stays 0 until `ch_en` has been sampled low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | 1 | Channel enable |
| xfer_width | input | 2 | Transfer width code |
| sg_mode | input | 1 | Scatter/gather mode |
| irq_en | input | 1 | Channel interrupt enable |
| tc_en | input | 1 | Terminal-count interrupt enable |
| q_tc | input | 1 | Descriptor qualifier for terminal count |
| q_eot | input | 1 | Descriptor qualifier for end of transfer |
| q_err | input | 1 | Descriptor qualifier for error |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| desc_addr | input | AW | Descriptor address |
| pair_active | input | 1 | A read/write pair is in flight |
| pair_done | input | 1 | The in-flight pair completes this cycle |
| slv_err | input | 1 | Slave error pulse |
| bus_tmo | input | 1 | Bus timeout pulse |
| tc_evt | input | 1 | Terminal count reached |
| eot_evt | input | 1 | End of transfer |
| clr_wr | input | 1 | Write strobe for clearing status |
| clr_mask | input | 3 | Write-one-to-clear mask: bit 0 tc, bit 1 eot, bit 2 err |
| busy | output | 1 | Channel allowed to transfer |
| st_tc | output | 1 | Terminal-count status |
| st_eot | output | 1 | End-of-transfer status |
| st_err | output | 1 | Error status |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a slave error that is held pending. It arrives while a pair is in flight and must stay invisible for several cycles, then appear on the exact edge where that pair finishes. The stimulus holds `pair_active` high, pulses `slv_err`, checks `st_err` over idle cycles and then pulses `pair_done`. A second hard spot is the rule that a fault keeps the channel locked even after the status is cleared. The bench clears `st_err` while `ch_en` stays high and checks that `busy` stays 0 until a full disable and re-enable.

// File: rtl/dma_chan_errirq.sv
module dma_chan_errirq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_en,
  input  logic [1:0]    xfer_width,
  input  logic          sg_mode,
  input  logic          irq_en,
  input  logic          tc_en,
  input  logic          q_tc,
  input  logic          q_eot,
  input  logic          q_err,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] desc_addr,
  input  logic          pair_active,
  input  logic          pair_done,
  input  logic          slv_err,
  input  logic          bus_tmo,
  input  logic          tc_evt,
  input  logic          eot_evt,
  input  logic          clr_wr,
  input  logic [2:0]    clr_mask,
  output logic          busy,
  output logic          st_tc,
  output logic          st_eot,
  output logic          st_err,
  output logic          irq
);
  logic       en_q, slv_pend;
  logic [2:0] wmask;
  logic       en_rise, misalign, slv_report, fault;

  always_comb begin
    case (xfer_width)
      2'd0:    wmask = 3'b000;
      2'd1:    wmask = 3'b001;
      2'd2:    wmask = 3'b011;
      default: wmask = 3'b111;
    endcase
  end

  assign en_rise    = ch_en & ~en_q;
  assign misalign   = (|(src_addr[2:0] & wmask)) | (|(dst_addr[2:0] & wmask))
                    | (sg_mode & (|desc_addr[1:0]));
  assign slv_report = (slv_err | slv_pend) & (~pair_active | pair_done);
  assign fault      = bus_tmo | slv_report | (en_rise & misalign);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      slv_pend <= 1'b0;
      busy     <= 1'b0;
    end else begin
      en_q     <= ch_en;
      slv_pend <= (slv_err | slv_pend) & ~slv_report;
      if (fault || !ch_en) busy <= 1'b0;
      else if (en_rise)    busy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_tc  <= 1'b0;
      st_eot <= 1'b0;
      st_err <= 1'b0;
    end else begin
      st_tc  <= tc_evt  | (st_tc  & ~(clr_wr & clr_mask[0]));
      st_eot <= eot_evt | (st_eot & ~(clr_wr & clr_mask[1]));
      st_err <= fault   | (st_err & ~(clr_wr & clr_mask[2]));
    end
  end

  assign irq = irq_en & ( (tc_en & st_tc & (~sg_mode | q_tc))
                        | (st_eot & (~sg_mode | q_eot))
                        | (st_err & (~sg_mode | q_err)) );
endmodule

// File: rtl/dma_chan_errirq_chk.sv
module dma_chan_errirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_en,
  input logic       irq_en,
  input logic       pair_active,
  input logic       pair_done,
  input logic       slv_err,
  input logic       bus_tmo,
  input logic       clr_wr,
  input logic [2:0] clr_mask,
  input logic       busy,
  input logic       st_err,
  input logic       irq
);
  AST_TMO_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tmo |=> (st_err && !busy)); // R4
  AST_SLV_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_err && !pair_active) |=> st_err); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !(clr_wr && clr_mask[2])) |=> st_err); // R10
  AST_BUSY_FROM_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ch_en)); // R3
  AST_FAULT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> !busy); // R11
endmodule

bind dma_chan_errirq dma_chan_errirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .irq_en(irq_en),
  .pair_active(pair_active), .pair_done(pair_done), .slv_err(slv_err),
  .bus_tmo(bus_tmo), .clr_wr(clr_wr), .clr_mask(clr_mask),
  .busy(busy), .st_err(st_err), .irq(irq)
);

// File: tb/sim_dma_chan_errirq.sv
`timescale 1ns/1ps
module sim_dma_chan_errirq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ch_en = 0, sg_mode = 0, irq_en = 0, tc_en = 0, q_tc = 0, q_eot = 0, q_err = 0;
  logic [1:0] xfer_width = 0;
  logic [31:0] src_addr = 0, dst_addr = 0, desc_addr = 0;
  logic pair_active = 0, pair_done = 0, slv_err = 0, bus_tmo = 0, tc_evt = 0, eot_evt = 0, clr_wr = 0;
  logic [2:0] clr_mask = 0;
  logic busy, st_tc, st_eot, st_err, irq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_errirq #(.AW(32)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_mask = 3'b111; step(); clr_wr = 0; clr_mask = 0;
  endtask

  task automatic try_enable(logic [1:0] w, logic sg, logic [31:0] s, logic [31:0] d,
                            logic [31:0] ds, logic exp_err, string req);
    ch_en = 0; step();
    clear_all();
    xfer_width = w; sg_mode = sg; src_addr = s; dst_addr = d; desc_addr = ds;
    ch_en = 1; step();
    chk({req, " err"}, st_err, exp_err);
    chk({req, " busy"}, busy, !exp_err);
    ch_en = 0; step();
  endtask

  task automatic t_reset();
    chk("R10 reset st", {st_tc, st_eot, st_err}, 0);
    chk("R3 reset busy", busy, 0);
    chk("R7 reset irq", irq, 0);
  endtask

  task automatic t_width();
    for (int w = 0; w < 4; w++) begin
      try_enable(w[1:0], 0, 32'h100 + (1 << w), 32'h200 + (1 << w), 0, 0, "R1 aligned");
      if (w > 0) begin
        try_enable(w[1:0], 0, 32'h100 + (1 << (w-1)), 32'h200, 0, 1, "R1 src misaligned");
        try_enable(w[1:0], 0, 32'h100, 32'h200 + 1, 0, 1, "R1 dst misaligned");
      end
    end
  endtask

  task automatic t_desc();
    try_enable(0, 0, 1, 3, 32'h2, 0, "R2 desc unchecked");
    try_enable(0, 1, 1, 3, 32'h2, 1, "R2 desc misaligned");
    try_enable(3, 1, 32'h8, 32'h10, 32'h4, 0, "R2 desc 4-aligned width 3");
  endtask

  task automatic t_timeout_lock();
    try_enable(2, 0, 4, 8, 0, 0, "R3 prep");
    ch_en = 1; step();
    chk("R3 busy after enable", busy, 1);
    bus_tmo = 1; step(); bus_tmo = 0;
    chk("R4 tmo err", st_err, 1);
    chk("R4 tmo busy", busy, 0);
    clear_all(); step(2);
    chk("R11 cleared err", st_err, 0);
    chk("R11 still locked", busy, 0);
    ch_en = 0; step(); ch_en = 1; step();
    chk("R11 re-enable busy", busy, 1);
  endtask

  task automatic t_slave();
    pair_active = 1; slv_err = 1; step(); slv_err = 0;
    chk("R5 held err", st_err, 0);
    step(2);
    chk("R5 still held", st_err, 0);
    chk("R5 busy while held", busy, 1);
    pair_done = 1; step(); pair_done = 0; pair_active = 0;
    chk("R5 err at pair end", st_err, 1);
    chk("R5 busy cleared", busy, 0);
    clear_all();
    slv_err = 1; step(); slv_err = 0;
    chk("R6 idle slave err", st_err, 1);
    ch_en = 0; step();
    clear_all();
  endtask

  task automatic t_irq();
    sg_mode = 0; irq_en = 0; eot_evt = 1; step(); eot_evt = 0;
    chk("R7 gated", irq, 0);
    irq_en = 1; step();
    chk("R8 eot irq", irq, 1);
    clr_wr = 1; clr_mask = 3'b010; step(); clr_wr = 0;
    chk("R10 eot cleared", st_eot, 0);
    chk("R8 irq drops", irq, 0);
    tc_en = 0; tc_evt = 1; step(); tc_evt = 0;
    chk("R8 tc without tc_en", irq, 0);
    tc_en = 1; step();
    chk("R8 tc with tc_en", irq, 1);
    sg_mode = 1; q_tc = 0; step();
    chk("R9 tc qual off", irq, 0);
    q_tc = 1; step();
    chk("R9 tc qual on", irq, 1);
    clear_all();
    bus_tmo = 1; q_err = 0; step(); bus_tmo = 0;
    chk("R9 err qual off", irq, 0);
    q_err = 1; step();
    chk("R9 err qual on", irq, 1);
    eot_evt = 1; clr_wr = 1; clr_mask = 3'b110; step(); eot_evt = 0; clr_wr = 0;
    chk("R10 set wins", st_eot, 1);
    chk("R10 masked clear", st_err, 0);
    q_eot = 0; step();
    chk("R9 eot qual off", irq, 0);
    irq_en = 0; step();
    chk("R7 gated sg", irq, 0);
    clear_all();
  endtask

  initial begin
    step(2); rst_n = 1; step();
    t_reset();
    t_width();
    t_desc();
    t_timeout_lock();
    t_slave();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule